// File: doc/BRIEF.md
# Three-Wire Serial Memory Slave

This block is the slave side of a byte-wide serial memory reached over three wires: a chip-select, a serial clock and one data line that turns around between the master and the slave. It holds a 256-byte array and a current-address pointer. The pointer survives from one transaction to the next, so a master can keep reading on from where the last access stopped without sending an address again. All three wires are sampled by a fast system clock. The data line appears at the block edge as a separate input, output and output-enable.

Raising chip-select while the serial clock is high opens a transaction. Lowering chip-select while the serial clock is high closes it. The first byte is a command. Right after it the slave drives a write-busy flag for one byte slot. What follows depends on the command: an address byte and write data, or read data from the pointer, or an address byte and then read data. Write data goes into a small buffer and reaches the array only after the closing edge. An internal write engine then stores the buffered bytes one at a time, each taking a set number of system clocks, and reports busy until it is done.

Top module: `serial_eeprom_slave`

## Requirements
- R1: After reset the data line is not driven (sdaOe = 0), every array byte reads 0x00, and the current-address pointer is 0.
- R2: A transaction opens only when chip-select rises while the serial clock is high. Chip-select rising while the serial clock is low opens nothing, and clocking bits in that state never drives the data line.
- R3: Commands are 8 bits sent most significant bit first: 0x00 is random write, 0x80 is current read and 0xC0 is random read. On the first falling edge after the eighth command bit, the slave drives the write-busy flag. It holds that value for eight serial clocks. The flag is 1 exactly when an internal write is in progress at the end of the command.
- R4: Any other command value still gets the flag slot. After the slot the data line is released for the rest of the transaction, and the pointer is left unchanged.
- R5: In random write, the address byte follows the flag slot, MSB first, and then the data bytes. Data byte k goes to address+k. Nothing is stored before the closing edge.
- R6: The write buffer holds 4 bytes. Data byte k occupies slot k mod 4, so later bytes overwrite earlier ones. On commit, slot i is stored at address+i for i below min(count, 4).
- R7: The internal write takes WRITE_CYCLES system clocks per byte and starts at the closing edge. The flag reads 1 during it and 0 once it has finished.
- R8: A random write whose command ends while busy is discarded. The array and the pointer keep their values.
- R9: In random read, the byte at the given address is returned first, followed by the bytes at the next addresses, each sent MSB first.
- R10: Current read returns data starting at the pointer. After a read the pointer equals the last read address + 1. After a committed write it equals the last written address + 1.
- R11: Addresses wrap modulo 256 during writes, reads and pointer updates.
- R12: Input bits are taken on the rising edge of the serial clock. The output value and output-enable change only after a falling edge, except that output-enable drops at a closing edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the serial wires |
| rstN | input | 1 | Active-low synchronous reset |
| sclIn | input | 1 | Serial clock from the master |
| csIn | input | 1 | Chip-select from the master, high while a transaction is open |
| sdaIn | input | 1 | Data line as seen by the slave |
| sdaOut | output | 1 | Value the slave drives on the data line |
| sdaOe | output | 1 | Output-enable for the data line |

## Verification
Directed transactions cover a read from an untouched array, a chip-select edge while the clock is low, a write issued during a busy period, a six-byte write that wraps the buffer, a write that crosses address 0xFF, and an unknown command. Each one isolates a single rule: framing, rejection, slot overwrite, address wrap or the unchanged pointer. A mixed random run then issues writes of 1 to 6 bytes and both kinds of read at random addresses. The reads are compared with a bench model of the array and pointer, so an error in the pointer update after a read or a write shows up as data from the wrong address.

// File: rtl/eep_pkg.sv
package eep_pkg;

  localparam int BYTE_W = 8;

  localparam logic [BYTE_W-1:0] CMD_WRITE    = 8'h00;
  localparam logic [BYTE_W-1:0] CMD_CURREAD  = 8'h80;
  localparam logic [BYTE_W-1:0] CMD_RANDREAD = 8'hC0;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CMD, ST_FLAG, ST_ADDR, ST_WDATA, ST_RDATA, ST_HALT
  } eepState_t;

  typedef enum logic [1:0] {
    OP_WRITE, OP_CURREAD, OP_RANDREAD, OP_NONE
  } eepOp_t;

  // one-cycle strobes from control to datapath
  typedef struct packed {
    logic shiftIn;
    logic latchFlag;
    logic showFlag;
    logic loadWrAddr;
    logic loadRdAddr;
    logic pushData;
    logic loadRead;
    logic shiftOut;
    logic commit;
  } eepStrobe_t;

endpackage

// File: rtl/eep_sync.sv
module eep_sync #(
  parameter int WIDTH = 3,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] rawIn,
  output logic [WIDTH-1:0] syncOut
);

  for (genvar g = 0; g < WIDTH; g++) begin : gBit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (!rstN) chain <= {STAGES{RESET_VAL[g]}};
      else       chain <= {chain[STAGES-2:0], rawIn[g]};
    end
    assign syncOut[g] = chain[STAGES-1];
  end

endmodule

// File: rtl/eep_ctrl.sv
module eep_ctrl
  import eep_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclRise,
  input  logic              sclFall,
  input  logic              startEvt,
  input  logic              stopEvt,
  input  logic [BYTE_W-1:0] rxByte,
  output eepStrobe_t        stb,
  output logic              sdaOe,
  output logic              inFlag
);

  eepState_t state, nState;
  eepOp_t    op, nOp;
  logic [2:0] bitCnt, nBit;
  logic       oeReg, nOe;

  function automatic eepOp_t decodeCmd(input logic [BYTE_W-1:0] c);
    case (c)
      CMD_WRITE:    return OP_WRITE;
      CMD_CURREAD:  return OP_CURREAD;
      CMD_RANDREAD: return OP_RANDREAD;
      default:      return OP_NONE;
    endcase
  endfunction

  always_comb begin
    stb    = '0;
    nState = state;
    nOp    = op;
    nBit   = bitCnt;
    nOe    = oeReg;
    if (stopEvt) begin
      stb.commit = (state == ST_WDATA);
      nState     = ST_IDLE;
      nOe        = 1'b0;
    end else if (startEvt) begin
      nState = ST_CMD;
      nBit   = '0;
      nOe    = 1'b0;
    end else begin
      case (state)
        ST_CMD: if (sclRise) begin
          stb.shiftIn = 1'b1;
          nBit        = 3'(bitCnt + 1);
          if (bitCnt == 3'd7) begin
            stb.latchFlag = 1'b1;
            nOp           = decodeCmd(rxByte);
            nState        = ST_FLAG;
          end
        end
        ST_FLAG: begin
          if (sclFall && bitCnt == 3'd0 && !oeReg) begin
            nOe          = 1'b1;
            stb.showFlag = 1'b1;
          end
          if (sclRise) begin
            nBit = 3'(bitCnt + 1);
            if (bitCnt == 3'd7) begin
              case (op)
                OP_WRITE, OP_RANDREAD: nState = ST_ADDR;
                OP_CURREAD:            nState = ST_RDATA;
                default:               nState = ST_HALT;
              endcase
            end
          end
        end
        ST_ADDR: begin
          if (sclFall) nOe = 1'b0;
          if (sclRise) begin
            stb.shiftIn = 1'b1;
            nBit        = 3'(bitCnt + 1);
            if (bitCnt == 3'd7) begin
              if (op == OP_WRITE) begin
                stb.loadWrAddr = 1'b1;
                nState         = ST_WDATA;
              end else begin
                stb.loadRdAddr = 1'b1;
                nState         = ST_RDATA;
              end
            end
          end
        end
        ST_WDATA: if (sclRise) begin
          stb.shiftIn  = 1'b1;
          nBit         = 3'(bitCnt + 1);
          stb.pushData = (bitCnt == 3'd7);
        end
        ST_RDATA: begin
          if (sclFall) begin
            nOe          = 1'b1;
            stb.loadRead = (bitCnt == 3'd0);
            stb.shiftOut = (bitCnt != 3'd0);
          end
          if (sclRise) nBit = 3'(bitCnt + 1);
        end
        ST_HALT: if (sclFall) nOe = 1'b0;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      op     <= OP_NONE;
      bitCnt <= '0;
      oeReg  <= 1'b0;
    end else begin
      state  <= nState;
      op     <= nOp;
      bitCnt <= nBit;
      oeReg  <= nOe;
    end
  end

  assign sdaOe  = oeReg;
  assign inFlag = (state == ST_FLAG);

endmodule

// File: rtl/eep_datapath.sv
module eep_datapath
  import eep_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int BUF_DEPTH = 4,
  parameter int WRITE_CYCLES = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  eepStrobe_t        stb,
  input  logic              sdaBit,
  output logic [BYTE_W-1:0] rxByte,
  output logic              sdaOut,
  output logic              wrBusy
);

  localparam int MEM_DEPTH = 1 << ADDR_W;
  localparam int BUF_IW    = (BUF_DEPTH > 1) ? $clog2(BUF_DEPTH) : 1;
  localparam int CNT_W     = $clog2(BUF_DEPTH + 1);
  localparam int TMR_W     = (WRITE_CYCLES > 1) ? $clog2(WRITE_CYCLES) : 1;

  logic [BYTE_W-1:0] memArr [MEM_DEPTH];
  logic [BYTE_W-1:0] bufArr [BUF_DEPTH];
  logic [BYTE_W-1:0] rxShift, txShift;
  logic              txBit, flagReg, writeOk, wrActive;
  logic [ADDR_W-1:0] curAddr, bufAddr, wrAddr;
  logic [BUF_IW-1:0] bufWrIdx, wrRdIdx;
  logic [CNT_W-1:0]  bufCnt, wrLeft;
  logic [TMR_W-1:0]  wrTimer;
  logic              wrFire;

  assign rxByte = {rxShift[BYTE_W-2:0], sdaBit};
  assign wrFire = wrActive && (wrTimer == TMR_W'(WRITE_CYCLES - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < MEM_DEPTH; i++) memArr[i] <= '0;
    end else if (wrFire) begin
      memArr[wrAddr] <= bufArr[wrRdIdx];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < BUF_DEPTH; i++) bufArr[i] <= '0;
    end else if (stb.pushData) begin
      bufArr[bufWrIdx] <= rxByte;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxShift  <= '0;
      txShift  <= '0;
      txBit    <= 1'b0;
      flagReg  <= 1'b0;
      writeOk  <= 1'b0;
      wrActive <= 1'b0;
      curAddr  <= '0;
      bufAddr  <= '0;
      wrAddr   <= '0;
      bufWrIdx <= '0;
      wrRdIdx  <= '0;
      bufCnt   <= '0;
      wrLeft   <= '0;
      wrTimer  <= '0;
    end else begin
      if (stb.shiftIn) rxShift <= rxByte;
      if (stb.latchFlag) begin
        flagReg  <= wrActive;
        writeOk  <= !wrActive;
        bufCnt   <= '0;
        bufWrIdx <= '0;
      end
      if (stb.showFlag) txBit <= flagReg;
      if (stb.loadWrAddr) bufAddr <= ADDR_W'(rxByte);
      if (stb.pushData) begin
        bufWrIdx <= (bufWrIdx == BUF_IW'(BUF_DEPTH - 1)) ? '0 : BUF_IW'(bufWrIdx + 1'b1);
        if (bufCnt != CNT_W'(BUF_DEPTH)) bufCnt <= CNT_W'(bufCnt + 1'b1);
      end
      if (stb.commit && writeOk && bufCnt != '0 && !wrActive) begin
        wrActive <= 1'b1;
        wrTimer  <= '0;
        wrAddr   <= bufAddr;
        wrRdIdx  <= '0;
        wrLeft   <= bufCnt;
      end
      if (wrActive) begin
        if (wrFire) begin
          wrTimer <= '0;
          wrAddr  <= ADDR_W'(wrAddr + 1'b1);
          curAddr <= ADDR_W'(wrAddr + 1'b1);
          wrRdIdx <= BUF_IW'(wrRdIdx + 1'b1);
          wrLeft  <= CNT_W'(wrLeft - 1'b1);
          if (wrLeft == CNT_W'(1)) wrActive <= 1'b0;
        end else begin
          wrTimer <= TMR_W'(wrTimer + 1'b1);
        end
      end
      if (stb.loadRdAddr) curAddr <= ADDR_W'(rxByte);
      if (stb.loadRead) begin
        txBit   <= memArr[curAddr][BYTE_W-1];
        txShift <= memArr[curAddr] << 1;
        curAddr <= ADDR_W'(curAddr + 1'b1);
      end
      if (stb.shiftOut) begin
        txBit   <= txShift[BYTE_W-1];
        txShift <= txShift << 1;
      end
    end
  end

  assign sdaOut = txBit;
  assign wrBusy = wrActive;

endmodule

// File: rtl/serial_eeprom_slave.sv
module serial_eeprom_slave
  import eep_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int BUF_DEPTH = 4,
  parameter int WRITE_CYCLES = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic csIn,
  input  logic sdaIn,
  output logic sdaOut,
  output logic sdaOe
);

  logic [2:0] pinSync;
  logic       sclLvl, csLvl, sdaLvl, sclPrev, csPrev;
  logic       sclRise, sclFall, startEvt, stopEvt, inFlag, wrBusy;
  logic [BYTE_W-1:0] rxByte;
  eepStrobe_t stb;

  eep_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RESET_VAL(3'b101)) u_sync (
    .clk(clk), .rstN(rstN), .rawIn({sdaIn, csIn, sclIn}), .syncOut(pinSync)
  );

  assign {sdaLvl, csLvl, sclLvl} = pinSync;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclPrev <= 1'b1;
      csPrev  <= 1'b0;
    end else begin
      sclPrev <= sclLvl;
      csPrev  <= csLvl;
    end
  end

  assign sclRise  = sclLvl && !sclPrev;
  assign sclFall  = !sclLvl && sclPrev;
  assign startEvt = csLvl && !csPrev && sclLvl;
  assign stopEvt  = !csLvl && csPrev && sclLvl;

  eep_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .sclRise(sclRise), .sclFall(sclFall),
    .startEvt(startEvt), .stopEvt(stopEvt), .rxByte(rxByte),
    .stb(stb), .sdaOe(sdaOe), .inFlag(inFlag)
  );

  eep_datapath #(.ADDR_W(ADDR_W), .BUF_DEPTH(BUF_DEPTH), .WRITE_CYCLES(WRITE_CYCLES)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .sdaBit(sdaLvl),
    .rxByte(rxByte), .sdaOut(sdaOut), .wrBusy(wrBusy)
  );

endmodule

// File: rtl/eep_checker.sv
module eep_checker (
  input logic clk,
  input logic rstN,
  input logic sdaOut,
  input logic sdaOe,
  input logic sclFall,
  input logic stopEvt,
  input logic inFlag,
  input logic wrBusy
);

  AST_OE_RISE_AFTER_FALL: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaOe) |-> $past(sclFall)); // R12

  AST_OUT_MOVES_AFTER_FALL: assert property (@(posedge clk) disable iff (!rstN)
    (sdaOe && $past(sdaOe) && !$stable(sdaOut)) |-> $past(sclFall)); // R12

  AST_FLAG_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (inFlag && $past(inFlag) && $past(sdaOe)) |-> $stable(sdaOut)); // R3

  AST_WRITE_AFTER_STOP: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wrBusy) |-> $past(stopEvt)); // R5

  AST_OE_FALL_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sdaOe) |-> ($past(sclFall) || $past(stopEvt) || $past(inFlag) == 1'b0)); // R12

endmodule

bind serial_eeprom_slave eep_checker u_chk (
  .clk(clk), .rstN(rstN), .sdaOut(sdaOut), .sdaOe(sdaOe),
  .sclFall(sclFall), .stopEvt(stopEvt), .inFlag(inFlag), .wrBusy(wrBusy)
);

// File: tb/tb_serial_eeprom_slave.sv
module tb_serial_eeprom_slave;

  localparam int HALF = 8;
  localparam int WAIT_WR = 400;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclIn = 1'b1;
  logic csIn = 1'b0;
  logic sdaIn = 1'b1;
  logic sdaOut, sdaOe;

  int checks = 0;
  int fails = 0;

  logic [7:0] model [256];
  logic [7:0] wbuf [8];
  int curP = 0;

  always #10 clk = ~clk;

  serial_eeprom_slave dut (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .csIn(csIn), .sdaIn(sdaIn),
    .sdaOut(sdaOut), .sdaOe(sdaOe)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic startT();
    csIn = 1'b1;
    tick(HALF);
  endtask

  task automatic stopT();
    csIn = 1'b0;
    tick(2 * HALF);
  endtask

  task automatic sendByte(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) begin
      sclIn = 1'b0;
      tick(4);
      sdaIn = v[i];
      tick(HALF - 4);
      sclIn = 1'b1;
      tick(HALF);
    end
  endtask

  task automatic recvByte(output logic [7:0] v, output int oeCnt);
    oeCnt = 0;
    for (int i = 7; i >= 0; i--) begin
      sclIn = 1'b0;
      tick(HALF);
      v[i] = sdaOut;
      if (sdaOe) oeCnt++;
      sclIn = 1'b1;
      tick(HALF);
    end
  endtask

  task automatic flagSlot(input bit expFlag, input string req);
    logic [7:0] f;
    int oeCnt;
    recvByte(f, oeCnt);
    check(f == (expFlag ? 8'hFF : 8'h00) && oeCnt == 8, req, "busy flag slot",
          {oeCnt[7:0], f}, {8'd8, (expFlag ? 8'hFF : 8'h00)});
  endtask

  function automatic void modelWrite(input int addr, input int n);
    logic [7:0] slot [4];
    int k;
    for (int i = 0; i < 4; i++) slot[i] = 8'h00;
    for (int i = 0; i < n; i++) slot[i % 4] = wbuf[i];
    k = (n < 4) ? n : 4;
    for (int i = 0; i < k; i++) model[(addr + i) % 256] = slot[i];
    if (k > 0) curP = (addr + k) % 256;
  endfunction

  task automatic doWrite(input int addr, input int n, input bit expFlag, input string req);
    startT();
    sendByte(8'h00);
    flagSlot(expFlag, req);
    sendByte(addr[7:0]);
    for (int i = 0; i < n; i++) sendByte(wbuf[i]);
    stopT();
    if (!expFlag) modelWrite(addr, n);
  endtask

  task automatic doRead(input bit rnd, input int addr, input int n, input string req);
    logic [7:0] v;
    int oeCnt, p;
    startT();
    sendByte(rnd ? 8'hC0 : 8'h80);
    flagSlot(1'b0, "R3");
    if (rnd) begin
      sendByte(addr[7:0]);
      p = addr;
    end else begin
      p = curP;
    end
    for (int i = 0; i < n; i++) begin
      recvByte(v, oeCnt);
      check(v == model[p % 256] && oeCnt == 8, req, $sformatf("read byte addr 0x%0h", p % 256),
            {oeCnt[7:0], v}, {8'd8, model[p % 256]});
      p++;
    end
    curP = p % 256;
    stopT();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int oeCnt;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 256; i++) model[i] = 8'h00;

    // R1: reset state
    tick(10);
    check(sdaOe == 1'b0, "R1", "sdaOe in reset", int'(sdaOe), 0);
    rstN = 1'b1;
    tick(10);
    check(sdaOe == 1'b0, "R1", "sdaOe after reset", int'(sdaOe), 0);
    doRead(1'b0, 0, 3, "R1");

    // R2: chip-select rising with clock low opens nothing
    sclIn = 1'b0;
    tick(HALF);
    csIn = 1'b1;
    tick(HALF);
    sendByte(8'h80);
    recvByte(v, oeCnt);
    check(oeCnt == 0, "R2", "drive after false start", oeCnt, 0);
    stopT();

    // R5, R7, R8: write, then a write while busy is rejected
    wbuf[0] = 8'hA1; wbuf[1] = 8'hB2; wbuf[2] = 8'hC3;
    doWrite(8'h10, 3, 1'b0, "R3");
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
    doWrite(8'h10, 3, 1'b1, "R7");
    tick(WAIT_WR);
    doRead(1'b1, 8'h10, 3, "R8");
    doRead(1'b0, 0, 2, "R10");

    // R6: six bytes wrap in the four-slot buffer
    for (int i = 0; i < 6; i++) wbuf[i] = 8'(8'h50 + i);
    doWrite(8'h40, 6, 1'b0, "R7");
    tick(WAIT_WR);
    doRead(1'b0, 0, 1, "R10");
    doRead(1'b1, 8'h40, 5, "R6");

    // R11: address wrap across 0xFF
    wbuf[0] = 8'hE0; wbuf[1] = 8'hE1; wbuf[2] = 8'hE2; wbuf[3] = 8'hE3;
    doWrite(8'hFE, 4, 1'b0, "R7");
    tick(WAIT_WR);
    doRead(1'b0, 0, 2, "R11");
    doRead(1'b1, 8'hFE, 4, "R11");

    // R4: unknown command
    startT();
    sendByte(8'h55);
    flagSlot(1'b0, "R4");
    recvByte(v, oeCnt);
    check(oeCnt == 0, "R4", "drive after unknown command", oeCnt, 0);
    stopT();
    doRead(1'b0, 0, 1, "R4");

    // R9, R10, R12: mixed random traffic
    for (int it = 0; it < 24; it++) begin
      int kind, addr, n;
      kind = int'($urandom % 3);
      addr = int'($urandom % 256);
      if (kind == 0) begin
        n = 1 + int'($urandom % 6);
        for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
        doWrite(addr, n, 1'b0, "R5");
        tick(WAIT_WR);
      end else if (kind == 1) begin
        n = 1 + int'($urandom % 5);
        doRead(1'b1, addr, n, "R9");
      end else begin
        n = 1 + int'($urandom % 5);
        doRead(1'b0, 0, n, "R12");
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule